// File: doc/BRIEF.md
# DMA Bus Grant Handshake Controller

This block decides who owns a shared multiplexed address/data bus: the processor or an external DMA controller. The DMA controller asks for the bus by pulling an active-low request. The request only counts while the DMA-enable output is high, and software sets or clears that output with an internal I/O command. A grant is taken and given back only on the falling edge of the system sync clock. While the grant is held, the block lowers its acknowledge and turns the bus buffers round: the transceiver direction control goes low so the transceivers drive the local bus, and the control-buffer disable goes low.

Two external inputs override software. Holding the timer-disable input low at once masks the DMA-enable output low, takes away any grant and keeps the acknowledge high. I/O commands that reach the enable bit during that time are ignored, so normal operation picks up with the enable value that was there before. A low hold-acknowledge from the execution unit drives both buffer controls low in the same way as a grant, but leaves the DMA handshake alone. When neither a grant nor a hold is active, the direction control follows the processor's own read/write direction and the control buffers stay enabled.

The block runs on a fast system clock. The sync clock and all other inputs except the request are taken to be synchronous to it. The request is asynchronous and passes through a two-flop synchronizer.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, dma_ack_n is 1, dma_en is 0, ctl_buf_dis_n is 1 and xcvr_dir_n equals cpu_dir.
- R2: While tmr_dis_n is 1, a clock with io_cmd_valid=1 loads io_cmd_enable into the enable bit, and dma_en shows it from the next clock.
- R3: While dma_en is 0, a low dma_req_n never makes dma_ack_n fall.
- R4: dma_req_n passes through two flops. dma_ack_n falls one clock after the first sync_clk high-to-low transition at which the synchronized request is low and dma_en is 1.
- R5: Once the synchronized request is high again, dma_ack_n rises one clock after the next sync_clk high-to-low transition.
- R6: While dma_ack_n is 0, xcvr_dir_n and ctl_buf_dis_n are both 0. With no grant and no hold, xcvr_dir_n equals cpu_dir and ctl_buf_dis_n is 1.
- R7: While tmr_dis_n is 0, dma_en reads 0 and dma_ack_n reads 1 in the same cycle, any grant is dropped, and I/O commands are ignored. After tmr_dis_n returns high, dma_en shows the value it had before.
- R8: While hold_ack_n is 0, xcvr_dir_n and ctl_buf_dis_n are 0. The hold has no effect on dma_ack_n or dma_en.
- R9: Clearing the enable while a grant is held does not end the grant. It ends only through R5 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_clk | input | 1 | System sync clock, sampled on clk; its falling edge times grant and release |
| dma_req_n | input | 1 | Asynchronous active-low DMA bus request |
| io_cmd_valid | input | 1 | Internal I/O command strobe targeting the enable bit |
| io_cmd_enable | input | 1 | Value written by the command (1 enables DMA) |
| tmr_dis_n | input | 1 | Active-low external disable; overrides the enable and the grant |
| hold_ack_n | input | 1 | Active-low hold acknowledge from the execution unit |
| cpu_dir | input | 1 | Processor read/write direction used for the transceivers in normal operation |
| dma_en | output | 1 | DMA-enable output |
| dma_ack_n | output | 1 | Active-low DMA acknowledge |
| xcvr_dir_n | output | 1 | Data transceiver direction control; 0 makes the transceivers drive the local bus |
| ctl_buf_dis_n | output | 1 | Active-low disable for the control signal buffers |

## Verification
The hardest case to reach is a grant that outlives its enable (R9), and close to it a disable pulse that arrives during a grant while an enable command is pending. To reach them, the stimulus first sets the enable with the request already low. It waits for the grant to form on a sync-clock fall and only then sends the clearing command or lowers tmr_dis_n. The reference model in the bench tracks the synchronizer delay and the sync-clock phase, so the release and the regrant are checked on the exact clock where they should occur.

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clk,
  input  logic dma_req_n,
  input  logic io_cmd_valid,
  input  logic io_cmd_enable,
  input  logic tmr_dis_n,
  input  logic hold_ack_n,
  input  logic cpu_dir,
  output logic dma_en,
  output logic dma_ack_n,
  output logic xcvr_dir_n,
  output logic ctl_buf_dis_n
);

  logic req_s1, req_s2;
  logic sclk_q;
  logic en_q;
  logic grant_q;
  logic sclk_fall;
  logic req_on;
  logic bus_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_s1 <= 1'b1;
      req_s2 <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      req_s1 <= dma_req_n;
      req_s2 <= req_s1;
      sclk_q <= sync_clk;
    end
  end

  assign sclk_fall = sclk_q & ~sync_clk;
  assign req_on    = ~req_s2;

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= 1'b0;
    else if (tmr_dis_n && io_cmd_valid)
      en_q <= io_cmd_enable;
  end

  assign dma_en = en_q & tmr_dis_n;

  always_ff @(posedge clk) begin
    if (!rst_n)
      grant_q <= 1'b0;
    else if (!tmr_dis_n)
      grant_q <= 1'b0;
    else if (sclk_fall) begin
      if (!grant_q && req_on && dma_en)
        grant_q <= 1'b1;
      else if (grant_q && !req_on)
        grant_q <= 1'b0;
    end
  end

  assign dma_ack_n     = ~(grant_q & tmr_dis_n);
  assign bus_taken     = ~dma_ack_n | ~hold_ack_n;
  assign xcvr_dir_n    = bus_taken ? 1'b0 : cpu_dir;
  assign ctl_buf_dis_n = ~bus_taken;

  assert_ack_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_ack_n) |-> $past(dma_en));

  assert_grant_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_ack_n) |-> $past(sclk_fall) && $past(req_on));

  assert_release_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dma_ack_n) && tmr_dis_n) |-> $past(sclk_fall) && !$past(req_on));

  assert_bufs_follow_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_ack_n |-> (!xcvr_dir_n && !ctl_buf_dis_n));

  assert_disable_drops_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_dis_n |=> !grant_q);

  assert_disable_freezes_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_dis_n |=> $stable(en_q));

  assert_hold_bufs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (!xcvr_dir_n && !ctl_buf_dis_n));

  assert_grant_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(grant_q) && tmr_dis_n && !($past(sclk_fall) && !$past(req_on))) |-> grant_q);

endmodule

// File: tb/sim_dma_bus_arbiter.sv
module sim_dma_bus_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_clk = 1'b1;
  logic dma_req_n = 1'b1;
  logic io_cmd_valid = 1'b0;
  logic io_cmd_enable = 1'b0;
  logic tmr_dis_n = 1'b1;
  logic hold_ack_n = 1'b1;
  logic cpu_dir = 1'b0;
  logic dma_en, dma_ack_n, xcvr_dir_n, ctl_buf_dis_n;

  int checks = 0;
  int fails = 0;
  int phase = 0;
  bit done = 0;

  bit q[$];
  bit m_prev, m_en, m_gnt;

  always #5 clk = ~clk;

  dma_bus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .sync_clk(sync_clk), .dma_req_n(dma_req_n),
    .io_cmd_valid(io_cmd_valid), .io_cmd_enable(io_cmd_enable),
    .tmr_dis_n(tmr_dis_n), .hold_ack_n(hold_ack_n), .cpu_dir(cpu_dir),
    .dma_en(dma_en), .dma_ack_n(dma_ack_n), .xcvr_dir_n(xcvr_dir_n),
    .ctl_buf_dis_n(ctl_buf_dis_n)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {};
      q.push_back(1'b1);
      q.push_back(1'b1);
      m_prev = 1'b1;
      m_en = 1'b0;
      m_gnt = 1'b0;
    end else begin
      bit fall, sreq, en_out;
      fall = m_prev && !sync_clk;
      sreq = q.pop_front();
      q.push_back(dma_req_n);
      en_out = m_en && tmr_dis_n;
      if (!tmr_dis_n) m_gnt = 1'b0;
      else if (fall) begin
        if (!m_gnt && !sreq && en_out) m_gnt = 1'b1;
        else if (m_gnt && sreq) m_gnt = 1'b0;
      end
      if (tmr_dis_n && io_cmd_valid) m_en = io_cmd_enable;
      m_prev = sync_clk;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic step();
    bit e_en, e_ack, busy;
    @(negedge clk);
    if (rst_n) begin
      e_en  = m_en && tmr_dis_n;
      e_ack = !(m_gnt && tmr_dis_n);
      busy  = !e_ack || !hold_ack_n;
      check("R2/R7 dma_en", dma_en, e_en);
      check("R3/R4/R5/R9 dma_ack_n", dma_ack_n, e_ack);
      check("R6/R8 xcvr_dir_n", xcvr_dir_n, busy ? 1'b0 : cpu_dir);
      check("R6/R8 ctl_buf_dis_n", ctl_buf_dis_n, !busy);
    end
    phase++;
    if (phase % 4 == 0) sync_clk = ~sync_clk;
    if (phase % 7 == 0) cpu_dir = ~cpu_dir;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cmd(bit v);
    io_cmd_valid = 1'b1;
    io_cmd_enable = v;
    step();
    io_cmd_valid = 1'b0;
  endtask

  initial begin
    steps(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", dma_ack_n, 1'b1);
    check("R1", dma_en, 1'b0);
    check("R1", ctl_buf_dis_n, 1'b1);
    check("R1", xcvr_dir_n, cpu_dir);
    steps(10);

    dma_req_n = 1'b0;
    steps(30);
    check("R3", dma_ack_n, 1'b1);

    cmd(1'b1);
    step();
    check("R2", dma_en, 1'b1);
    steps(20);
    check("R4", dma_ack_n, 1'b0);
    check("R6", xcvr_dir_n, 1'b0);
    check("R6", ctl_buf_dis_n, 1'b0);

    cmd(1'b0);
    steps(20);
    check("R9", dma_ack_n, 1'b0);
    check("R2", dma_en, 1'b0);

    dma_req_n = 1'b1;
    steps(20);
    check("R5", dma_ack_n, 1'b1);
    check("R6", ctl_buf_dis_n, 1'b1);

    cmd(1'b1);
    dma_req_n = 1'b0;
    steps(20);
    check("R4", dma_ack_n, 1'b0);
    tmr_dis_n = 1'b0;
    step();
    check("R7", dma_ack_n, 1'b1);
    check("R7", dma_en, 1'b0);
    cmd(1'b0);
    steps(10);
    check("R7", dma_ack_n, 1'b1);
    tmr_dis_n = 1'b1;
    step();
    check("R7", dma_en, 1'b1);
    steps(20);
    check("R4", dma_ack_n, 1'b0);
    dma_req_n = 1'b1;
    steps(20);

    hold_ack_n = 1'b0;
    step();
    check("R8", xcvr_dir_n, 1'b0);
    check("R8", ctl_buf_dis_n, 1'b0);
    check("R8", dma_ack_n, 1'b1);
    check("R8", dma_en, 1'b1);
    steps(15);
    hold_ack_n = 1'b1;
    step();
    check("R8", ctl_buf_dis_n, 1'b1);

    for (int k = 0; k < 40; k++) begin
      dma_req_n = k[1];
      hold_ack_n = !(k % 9 == 0);
      if (k % 11 == 5) cmd(k[2]);
      steps(3 + (k % 5));
    end
    dma_req_n = 1'b1;
    steps(20);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule